// File: doc/BRIEF.md
# External Bus Access Phase Sequencer

This block times one access on an external memory bus as a run of up to six programmable phases, named A to F. When it is idle and sees a start request, it captures a 15-bit timing word, a read/write flag, a ready-enable bit and a ready-mode bit. It then steps through every phase whose programmed length is not zero, always in the order A, B, C, D, E, F. A phase with zero length is skipped and costs no clock.

Phase E is the access window, and the strobe output is high for all of it. If ready waiting is enabled, phase E lasts at least its programmed minimum. It then continues until the READY input is seen active. READY is used either directly (synchronous mode) or after a two-flop synchronizer (asynchronous mode). The final phase F takes its length from a read field or from a write field, chosen by the captured direction. A one-clock done pulse marks the end of the access. Pin driving, address and data multiplexing, and chip-select decoding are left to the surrounding logic.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset, phase_o is 0 (idle), and busy_o, done_o and strobe_o are all low.
- R2: Timing bits [1:0] give the phase A length, 0 to 3 clocks. A value of 0 skips phase A.
- R3: Timing bit [2] gives the phase B length: 0 means 1 clock and 1 means 2 clocks.
- R4: Timing bits [4:3] give the phase C length (0 to 3 clocks). Bit [5] gives the phase D length (0 or 1 clock). A zero length skips the phase.
- R5: Timing bits [10:6] give the phase E length as the field value plus one (1 to 32 clocks).
- R6: Phase F lasts timing bits [12:11] clocks on a read (write_i=0) and timing bits [14:13] clocks on a write (write_i=1). A zero length skips it.
- R7: phase_o encodes idle=0, A=1, B=2, C=3, D=4, E=5, F=6. The phases appear in rising order with no idle clock between them. The first active phase is shown in the clock after the start is accepted. busy_o is high exactly while phase_o is not 0. strobe_o is high exactly while phase_o is 5.
- R8: With ready-enable low, phase E lasts exactly its programmed length, whatever READY does.
- R9: With ready-enable high and ready-mode 1 (synchronous), phase E ends at the first clock edge where its minimum has elapsed and ready_i is high at that edge.
- R10: With ready-enable high and ready-mode 0 (asynchronous), ready_i passes through two flops first. If READY rises during E cycle m, phase E lasts the larger of m+2 and its minimum.
- R11: done_o is high for exactly one clock, in the clock after the last active phase. In that clock phase_o is 0 and busy_o is low.
- R12: A start request while busy is ignored. The timing word, direction and ready bits are captured when the start is accepted, so later changes to those inputs have no effect on the access in progress.
- R13: A start request in the clock where done_o is high is accepted. Its first phase follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an access (acted on only when idle) |
| write_i | input | 1 | Access direction: 1 for write, 0 for read |
| timing_i | input | 15 | Phase timing word |
| rdy_en_i | input | 1 | Phase E also waits for READY |
| rdy_sync_mode_i | input | 1 | 1: READY is synchronous; 0: READY goes through the synchronizer |
| ready_i | input | 1 | External READY |
| phase_o | output | 3 | Current phase, idle=0, A..F=1..6 |
| busy_o | output | 1 | An access is in progress |
| done_o | output | 1 | One-clock end-of-access pulse |
| strobe_o | output | 1 | High throughout phase E |

## Verification
The end of one access and the start of the next can fall in the same clock. A start request in the done clock must be accepted, while a start request during any active phase must be dropped. The bench drives a second start in the exact clock where done_o is high and checks the first phase of the new access on the next clock. It also pulses start, with a different timing word, in the middle of an access and checks that every phase length still matches the first word. A second collision is the phase E minimum expiring in the same clock that READY is first seen. The bench raises READY before, at and after that point and checks the resulting phase E length.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int TW_W   = 15;
  localparam int NPH    = 7;
  localparam int LEN_W  = 6;
  localparam int CNT_W  = LEN_W - 1;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_A    = 3'd1,
    PH_B    = 3'd2,
    PH_C    = 3'd3,
    PH_D    = 3'd4,
    PH_E    = 3'd5,
    PH_F    = 3'd6
  } phase_e;

  // field placement is fixed by the timing word format
  typedef struct packed {
    logic [1:0] f_wr;
    logic [1:0] f_rd;
    logic [4:0] e_len;
    logic       d_len;
    logic [1:0] c_len;
    logic       b_len;
    logic [1:0] a_len;
  } timing_t;

  typedef logic [NPH-1:0][LEN_W-1:0] len_vec_t;
endpackage

// File: rtl/bps_ready_sync.sv
module bps_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic sync_mode_i,
  output logic rdy_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], ready_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // synchronous READY is taken straight from the pin
  assign rdy_o = sync_mode_i ? ready_i : chain_q[STAGES-1];
endmodule

// File: rtl/bps_len_decode.sv
module bps_len_decode
  import bps_pkg::*;
(
  input  timing_t  cfg_i,
  input  logic     write_i,
  output len_vec_t len_o
);
  always_comb begin
    len_o          = '0;
    len_o[PH_A]    = LEN_W'(cfg_i.a_len);
    len_o[PH_B]    = cfg_i.b_len ? LEN_W'(2) : LEN_W'(1);
    len_o[PH_C]    = LEN_W'(cfg_i.c_len);
    len_o[PH_D]    = LEN_W'(cfg_i.d_len);
    len_o[PH_E]    = LEN_W'(cfg_i.e_len) + LEN_W'(1);
    len_o[PH_F]    = write_i ? LEN_W'(cfg_i.f_wr) : LEN_W'(cfg_i.f_rd);
  end
endmodule

// File: rtl/bps_phase_fsm.sv
module bps_phase_fsm
  import bps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  timing_t  cfg_in,
  input  logic     write_in,
  input  logic     ren_in,
  input  logic     rmode_in,
  input  len_vec_t len_i,
  input  logic     rdy_i,
  output phase_e   phase_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     strobe_o,
  output timing_t  cfg_q_o,
  output logic     wr_q_o,
  output logic     rmode_q_o
);
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              cnt_en;
  logic              load_en;
  timing_t           cfg_q;
  logic              wr_q, ren_q, rmode_q;
  phase_e            succ;
  logic              may_leave;

  function automatic phase_e next_after(input logic [2:0] cur, input len_vec_t l);
    phase_e r;
    r = PH_IDLE;
    for (int i = NPH - 1; i >= 1; i--) begin
      if (i > int'(cur) && l[i] != '0) r = phase_e'(i[2:0]);
    end
    return r;
  endfunction

  always_comb begin
    succ      = next_after(phase_q, len_i);
    may_leave = (cnt_q == '0) && ((phase_q != PH_E) || !ren_q || rdy_i);
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    load_en   = 1'b0;
    cnt_en    = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_i) begin
        load_en = 1'b1;
        cnt_en  = 1'b1;
        phase_d = succ;
        cnt_d   = CNT_W'(len_i[succ] - LEN_W'(1));
      end
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end else if (may_leave) begin
      phase_d = succ;
      if (succ == PH_IDLE) begin
        done_d = 1'b1;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = CNT_W'(len_i[succ] - LEN_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      ren_q   <= 1'b0;
      rmode_q <= 1'b0;
    end else if (load_en) begin
      cfg_q   <= cfg_in;
      wr_q    <= write_in;
      ren_q   <= ren_in;
      rmode_q <= rmode_in;
    end
  end

  assign phase_o   = phase_q;
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign strobe_o  = (phase_q == PH_E);
  assign cfg_q_o   = cfg_q;
  assign wr_q_o    = wr_q;
  assign rmode_q_o = rmode_q;

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_IDLE));

  // R7
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q == PH_IDLE || phase_q >= $past(phase_q)));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q == PH_IDLE || ($stable(cfg_q) && $stable(wr_q) && $stable(ren_q))));

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_E && ren_q && !rdy_i) |=> (phase_q == PH_E));

  // R11
  done_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_IDLE || done_q));
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import bps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [TW_W-1:0]  timing_i,
  input  logic             rdy_en_i,
  input  logic             rdy_sync_mode_i,
  input  logic             ready_i,
  output logic [2:0]       phase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             strobe_o
);
  timing_t  cfg_q, cfg_sel;
  logic     wr_q, wr_sel, rmode_q;
  logic     busy;
  logic     rdy;
  len_vec_t lens;
  phase_e   phase;

  // idle: decode the incoming word to pick the first phase; busy: the captured one
  assign cfg_sel = busy ? cfg_q : timing_t'(timing_i);
  assign wr_sel  = busy ? wr_q  : write_i;

  bps_len_decode u_dec (
    .cfg_i   (cfg_sel),
    .write_i (wr_sel),
    .len_o   (lens)
  );

  bps_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready_i),
    .sync_mode_i (rmode_q),
    .rdy_o       (rdy)
  );

  bps_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cfg_in    (timing_t'(timing_i)),
    .write_in  (write_i),
    .ren_in    (rdy_en_i),
    .rmode_in  (rdy_sync_mode_i),
    .len_i     (lens),
    .rdy_i     (rdy),
    .phase_o   (phase),
    .busy_o    (busy),
    .done_o    (done_o),
    .strobe_o  (strobe_o),
    .cfg_q_o   (cfg_q),
    .wr_q_o    (wr_q),
    .rmode_q_o (rmode_q)
  );

  assign phase_o = phase;
  assign busy_o  = busy;
endmodule

// File: tb/bus_phase_seq_tb.sv
module bus_phase_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        write_i = 1'b0;
  logic [14:0] timing_i = '0;
  logic        rdy_en_i = 1'b0;
  logic        rdy_sync_mode_i = 1'b0;
  logic        ready_i = 1'b0;
  logic [2:0]  phase_o;
  logic        busy_o, done_o, strobe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bus_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .timing_i(timing_i), .rdy_en_i(rdy_en_i), .rdy_sync_mode_i(rdy_sync_mode_i),
    .ready_i(ready_i), .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o),
    .strobe_o(strobe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(int a, int b, int c, int d, int e, int fr, int fw);
    return {fw[1:0], fr[1:0], e[4:0], d[0], c[1:0], b[0], a[1:0]};
  endfunction

  function automatic int exp_len(logic [14:0] tw, logic wr, int ph);
    case (ph)
      1: return int'(tw[1:0]);
      2: return tw[2] ? 2 : 1;
      3: return int'(tw[4:3]);
      4: return int'(tw[5]);
      5: return int'(tw[10:6]) + 1;
      6: return wr ? int'(tw[14:13]) : int'(tw[12:11]);
      default: return 0;
    endcase
  endfunction

  // runs one access; returns per-phase clock counts and a count of rule breaks
  task automatic run_access(input logic [14:0] tw, input logic wr, input logic ren,
                            input logic rmode, input int raise_at, input int ghost_at,
                            output int seen[7], output int viol);
    int last;
    int idx;
    for (int i = 0; i < 7; i++) seen[i] = 0;
    viol = 0;
    last = 0;
    idx = 0;
    ready_i = 1'b0;
    repeat (3) @(negedge clk);
    timing_i = tw; write_i = wr; rdy_en_i = ren; rdy_sync_mode_i = rmode;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble captured inputs: they must not matter any more
    timing_i = ~tw; write_i = ~wr; rdy_en_i = ~ren; rdy_sync_mode_i = ~rmode;
    while (!done_o && idx < 300) begin
      if (phase_o == 3'd0 || int'(phase_o) < last || phase_o > 3'd6) viol++;
      if (busy_o != (phase_o != 3'd0)) viol++;
      if (strobe_o != (phase_o == 3'd5)) viol++;
      last = int'(phase_o);
      if (phase_o <= 3'd6) seen[phase_o]++;
      start_i = (idx == ghost_at);
      if (phase_o == 3'd5 && seen[5] == raise_at) ready_i = 1'b1;
      idx++;
      @(negedge clk);
    end
    start_i = 1'b0;
    ready_i = 1'b0;
    chk(done_o && !busy_o && phase_o == 3'd0, "R11 done clock idle", int'(phase_o), 0);
  endtask

  task automatic cmp_lens(input string tag, input logic [14:0] tw, input logic wr,
                          input int seen[7], input int e_override);
    for (int p = 1; p <= 6; p++) begin
      int e;
      e = (p == 5 && e_override >= 0) ? e_override : exp_len(tw, wr, p);
      chk(seen[p] == e, $sformatf("%s phase %0d length", tag, p), seen[p], e);
    end
  endtask

  task automatic t_reset;
    chk(phase_o == 3'd0 && !busy_o && !done_o && !strobe_o, "R1 reset outputs",
        {phase_o, busy_o, done_o, strobe_o}, 0);
  endtask

  task automatic t_full_read;
    int seen[7]; int viol;
    logic [14:0] tw;
    tw = mk(2, 1, 1, 1, 3, 2, 1);
    run_access(tw, 1'b0, 1'b0, 1'b0, -1, -1, seen, viol);
    cmp_lens("R2 R3 R4 R5 R6 read", tw, 1'b0, seen, -1);
    chk(viol == 0, "R7 order/busy/strobe", viol, 0);
    @(negedge clk);
    chk(!done_o, "R11 done one clock", int'(done_o), 0);
  endtask

  task automatic t_minimal;
    int seen[7]; int viol;
    logic [14:0] tw;
    tw = mk(0, 0, 0, 0, 0, 0, 3);
    run_access(tw, 1'b0, 1'b0, 1'b0, -1, -1, seen, viol);
    cmp_lens("R2 R4 R6 skip zero", tw, 1'b0, seen, -1);
    chk(viol == 0, "R7 no idle gap", viol, 0);
  endtask

  task automatic t_write;
    int seen[7]; int viol;
    logic [14:0] tw;
    tw = mk(1, 0, 2, 0, 1, 3, 1);
    run_access(tw, 1'b1, 1'b0, 1'b0, -1, -1, seen, viol);
    cmp_lens("R6 write F", tw, 1'b1, seen, -1);
    tw = mk(0, 1, 0, 1, 0, 2, 0);
    run_access(tw, 1'b1, 1'b0, 1'b0, -1, -1, seen, viol);
    cmp_lens("R6 write F zero", tw, 1'b1, seen, -1);
    chk(viol == 0, "R7 write order", viol, 0);
  endtask

  task automatic t_max;
    int seen[7]; int viol;
    logic [14:0] tw;
    tw = mk(3, 1, 3, 1, 31, 0, 3);
    run_access(tw, 1'b1, 1'b0, 1'b0, -1, -1, seen, viol);
    cmp_lens("R5 max lengths", tw, 1'b1, seen, -1);
  endtask

  task automatic t_ready_off;
    int seen[7]; int viol;
    logic [14:0] tw;
    tw = mk(0, 0, 0, 0, 2, 0, 0);
    run_access(tw, 1'b0, 1'b0, 1'b1, -1, -1, seen, viol);
    chk(seen[5] == 3, "R8 ready ignored when disabled", seen[5], 3);
  endtask

  task automatic t_ready_sync;
    int seen[7]; int viol;
    run_access(mk(0, 0, 0, 0, 0, 1, 0), 1'b0, 1'b1, 1'b1, 3, -1, seen, viol);
    chk(seen[5] == 3, "R9 sync ready late", seen[5], 3);
    run_access(mk(0, 0, 0, 0, 4, 1, 0), 1'b0, 1'b1, 1'b1, 2, -1, seen, viol);
    chk(seen[5] == 5, "R9 sync ready before minimum", seen[5], 5);
    run_access(mk(0, 0, 0, 0, 3, 0, 0), 1'b0, 1'b1, 1'b1, 4, -1, seen, viol);
    chk(seen[5] == 4, "R9 sync ready at minimum", seen[5], 4);
    chk(viol == 0, "R7 ready order", viol, 0);
  endtask

  task automatic t_ready_async;
    int seen[7]; int viol;
    run_access(mk(0, 0, 0, 0, 0, 0, 0), 1'b0, 1'b1, 1'b0, 3, -1, seen, viol);
    chk(seen[5] == 5, "R10 async ready delay", seen[5], 5);
    run_access(mk(0, 0, 0, 0, 7, 0, 0), 1'b0, 1'b1, 1'b0, 2, -1, seen, viol);
    chk(seen[5] == 8, "R10 async under minimum", seen[5], 8);
  endtask

  task automatic t_busy_ignore;
    int seen[7]; int viol;
    logic [14:0] tw;
    tw = mk(2, 1, 1, 0, 2, 1, 2);
    run_access(tw, 1'b0, 1'b0, 1'b0, -1, 3, seen, viol);
    cmp_lens("R12 start while busy", tw, 1'b0, seen, -1);
    repeat (2) begin
      @(negedge clk);
      chk(phase_o == 3'd0 && !busy_o, "R12 no extra access", int'(phase_o), 0);
    end
  endtask

  task automatic t_back_to_back;
    int seen[7]; int viol;
    run_access(mk(0, 0, 0, 0, 1, 1, 0), 1'b0, 1'b0, 1'b0, -1, -1, seen, viol);
    timing_i = mk(0, 1, 2, 0, 0, 0, 0); write_i = 1'b0; rdy_en_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(phase_o == 3'd2 && busy_o, "R13 start in done clock", int'(phase_o), 2);
    @(negedge clk);
    chk(phase_o == 3'd2, "R13 B second clock", int'(phase_o), 2);
    @(negedge clk);
    chk(phase_o == 3'd3, "R13 C follows", int'(phase_o), 3);
    repeat (10) @(negedge clk);
    chk(phase_o == 3'd0, "R13 access completes", int'(phase_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_read();
    t_minimal();
    t_write();
    t_max();
    t_ready_off();
    t_ready_sync();
    t_ready_async();
    t_busy_ignore();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule